// File: doc/BRIEF.md
# Processor Status Register with Interrupt Gating

This block is the status register of a small 8-bit processor core. It holds the global interrupt enable, a single bit-copy storage bit, and six arithmetic flags: half carry, sign, overflow, negative, zero and carry. Three sources can change the register. The ALU changes the arithmetic flags through a per-flag mask. The I/O bus rewrites the whole register. Bit-store and bit-load operations move single bits between a register-file operand and the copy bit.

The block also gates the core's interrupt request. A request reaches the core only when the global enable is set and at least one individually enabled source is asserting. When the core accepts an interrupt, the block drops the global enable. A return-from-interrupt sets it again. The register contents are never saved or restored automatically around an interrupt. Software handles that.

The sign flag is not stored. It is always formed from the current negative and overflow flags, so it can never disagree with them.

Top module: `status_reg`

## Requirements
- R1: After reset, all eight bits of `sreg_q` read 0.
- R2: A cycle with `io_we` high loads the register from `io_wdata` on the next clock edge. The bit layout, from bit 7 down to bit 0, is: global enable, copy bit, half carry, sign, overflow, negative, zero, carry.
- R3: `sreg_q[4]` always equals `sreg_q[2] ^ sreg_q[3]`. The value of `io_wdata[4]` has no effect.
- R4: When `io_we` is low, each high bit of `flag_mask` loads the matching bit of `flag_in` on the next edge. The matching is: index 4 is half carry, 3 is overflow, 2 is negative, 1 is zero, 0 is carry. Flags whose mask bit is low keep their value.
- R5: When `io_we` and a flag update occur in the same cycle, the flags take their values from `io_wdata`.
- R6: `irq_pending` equals the global enable ANDed with the OR of `irq_req & irq_en`, in the same cycle with no register delay. While the global enable is 0, `irq_pending` is 0.
- R7: `irq_take` clears the global enable on the next edge. It overrides `io_we` and `reti` in the same cycle.
- R8: `reti` sets the global enable on the next edge unless `irq_take` or `io_we` is also high. An I/O write in the same cycle overrides `reti`.
- R9: `bst_en` loads `operand[bit_sel]` into the copy bit on the next edge. `io_we` in the same cycle overrides it.
- R10: `bld_result` equals `operand` with bit `bit_sel` replaced by the copy bit. It is combinational.
- R11: `irq_take` and `reti` leave every bit except the global enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | Full-register write strobe from the I/O bus |
| io_wdata | input | 8 | I/O write data |
| flag_mask | input | 5 | Per-flag update enables {H,V,N,Z,C} |
| flag_in | input | 5 | New flag values {H,V,N,Z,C} from the ALU |
| bst_en | input | 1 | Bit-store: copy a selected operand bit into the copy bit |
| bit_sel | input | 3 | Bit index for bit-store and bit-load |
| operand | input | 8 | Register-file operand |
| bld_result | output | 8 | Operand with the selected bit replaced by the copy bit |
| irq_req | input | IRQ_N | Raw interrupt requests |
| irq_en | input | IRQ_N | Individual interrupt enables |
| irq_take | input | 1 | Core accepts an interrupt this cycle |
| reti | input | 1 | Return-from-interrupt executes this cycle |
| irq_pending | output | 1 | Gated interrupt request to the core |
| sreg_q | output | 8 | Register read value |

## Verification
`sreg_q` reflects a write, flag update, bit-store, take or return one clock edge after the strobe. The bench therefore compares it 1 ns after that edge, against a model that it advances on the same edge. `irq_pending` and `bld_result` have no register on their path. The bench checks them 1 ns after the inputs settle, before the next edge. Every control combination is applied with both values of the global enable, so that the priority rules are exercised from each starting state.

// File: rtl/status_reg.sv
module status_reg #(
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_we,
  input  logic [7:0]       io_wdata,
  input  logic [4:0]       flag_mask,
  input  logic [4:0]       flag_in,
  input  logic             bst_en,
  input  logic [2:0]       bit_sel,
  input  logic [7:0]       operand,
  output logic [7:0]       bld_result,
  input  logic [IRQ_N-1:0] irq_req,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             irq_take,
  input  logic             reti,
  output logic             irq_pending,
  output logic [7:0]       sreg_q
);
  localparam int HB = 4, VB = 3, NB = 2, ZB = 1, CB = 0;

  logic       gie_q, cpy_q;
  logic [4:0] fl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      cpy_q <= 1'b0;
      fl_q  <= '0;
    end else begin
      if (irq_take)   gie_q <= 1'b0;
      else if (io_we) gie_q <= io_wdata[7];
      else if (reti)  gie_q <= 1'b1;

      if (io_we)       cpy_q <= io_wdata[6];
      else if (bst_en) cpy_q <= operand[bit_sel];

      if (io_we) fl_q <= {io_wdata[5], io_wdata[3:0]};
      else       fl_q <= (fl_q & ~flag_mask) | (flag_in & flag_mask);
    end
  end

  assign sreg_q = {gie_q, cpy_q, fl_q[HB], fl_q[NB] ^ fl_q[VB],
                   fl_q[VB], fl_q[NB], fl_q[ZB], fl_q[CB]};

  assign irq_pending = gie_q & |(irq_req & irq_en);

  always_comb begin
    bld_result = operand;
    bld_result[bit_sel] = cpy_q;
  end

  // R7: a taken interrupt drops the global enable
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !sreg_q[7]);
  // R8: return re-arms when nothing overrides it
  a_r8_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_take && !io_we) |=> sreg_q[7]);
  // R2: an I/O write lands in the copy bit and the upper flags
  a_r2_io_load: assert property (@(posedge clk) disable iff (!rst_n)
    io_we |=> sreg_q[6:5] == $past(io_wdata[6:5]));
  // R4: an unmasked carry flag holds
  a_r4_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_we && !flag_mask[0]) |=> $stable(sreg_q[0]));
  // R9: bit-store copies the selected operand bit
  a_r9_bst: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_en && !io_we) |=> sreg_q[6] == $past(operand[bit_sel]));
  // R6: no request passes with the global enable low
  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sreg_q[7] |-> !irq_pending);
  // R11: take and return leave the flags alone
  a_r11_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_take || reti) && !io_we && flag_mask == 5'd0) |=> $stable(sreg_q[5:0]));
endmodule

// File: tb/status_reg_test.sv
`timescale 1ns/1ps
module status_reg_test;
  localparam int IRQ_N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_we = 0, bst_en = 0, irq_take = 0, reti = 0;
  logic [7:0] io_wdata = 0, operand = 0, bld_result, sreg_q;
  logic [4:0] flag_mask = 0, flag_in = 0;
  logic [2:0] bit_sel = 0;
  logic [IRQ_N-1:0] irq_req = 0, irq_en = 0;
  logic irq_pending;

  int vectors = 0, errors = 0, cycles = 0;
  logic mi, mt, mh, mv, mn, mz, mc;

  status_reg #(.IRQ_N(IRQ_N)) uut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_sreg();
    return {mi, mt, mh, mn ^ mv, mv, mn, mz, mc};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge: model advanced from requirement text, then compared
  task automatic tick(input string req);
    @(posedge clk);
    if (!rst_n) begin
      {mi, mt, mh, mv, mn, mz, mc} = '0;
    end else begin
      logic ni = irq_take ? 1'b0 : io_we ? io_wdata[7] : reti ? 1'b1 : mi;
      mt = io_we ? io_wdata[6] : bst_en ? operand[bit_sel] : mt;
      if (io_we) {mh, mv, mn, mz, mc} = {io_wdata[5], io_wdata[3:0]};
      else begin
        if (flag_mask[4]) mh = flag_in[4];
        if (flag_mask[3]) mv = flag_in[3];
        if (flag_mask[2]) mn = flag_in[2];
        if (flag_mask[1]) mz = flag_in[1];
        if (flag_mask[0]) mc = flag_in[0];
      end
      mi = ni;
    end
    #1 chk(req, sreg_q, exp_sreg());
  endtask

  task automatic idle();
    io_we = 0; bst_en = 0; irq_take = 0; reti = 0; flag_mask = 0;
  endtask

  initial begin
    tick("R1");
    tick("R1");
    rst_n = 1;
    chk("R1", sreg_q, 8'h00);

    // R2 R3: every I/O write value, S input ignored
    for (int v = 0; v < 256; v++) begin
      io_we = 1; io_wdata = v[7:0];
      tick("R2/R3");
    end
    idle();

    // R4: every mask with every flag pattern
    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        flag_mask = m[4:0]; flag_in = f[4:0];
        tick("R4");
      end
    end

    // R5: I/O write beats a flag update
    for (int k = 0; k < 32; k++) begin
      io_we = 1; io_wdata = 8'(k * 37); flag_mask = 5'h1f; flag_in = ~k[4:0];
      tick("R5");
    end
    idle();

    // R7 R8 R11 with R5 overlap: all control combinations from both enable states
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        idle(); io_we = 1; io_wdata = {s[0], 7'h2b ^ 7'(c)};
        tick("R2");
        {irq_take, reti, io_we, bst_en} = c[3:0];
        io_wdata = {~s[0], 7'h55};
        operand = 8'hc3; bit_sel = 3'(c);
        tick(c[3] ? "R7/R11" : c[2] ? "R8/R11" : "R9");
      end
    end
    idle();

    // R9: bit-store from every position
    for (int o = 0; o < 4; o++) begin
      for (int b = 0; b < 8; b++) begin
        bst_en = 1; operand = 8'(8'h5a ^ (o * 8'h33)); bit_sel = 3'(b);
        tick("R9");
      end
    end
    idle();

    // R10: bit-load with both copy-bit values
    for (int t = 0; t < 2; t++) begin
      io_we = 1; io_wdata = {1'b0, t[0], 6'h00};
      tick("R2");
      idle();
      for (int o = 0; o < 8; o++) begin
        for (int b = 0; b < 8; b++) begin
          logic [7:0] e;
          operand = 8'(o * 8'h29 + 8'h11); bit_sel = 3'(b);
          e = operand;
          e[b] = t[0];
          #1 chk("R10", bld_result, e);
        end
      end
    end

    // R6: all request/enable pairs under both enable states
    for (int g = 0; g < 2; g++) begin
      io_we = 1; io_wdata = {g[0], 7'h00};
      tick("R2");
      idle();
      for (int r = 0; r < 16; r++) begin
        for (int e = 0; e < 16; e++) begin
          irq_req = r[3:0]; irq_en = e[3:0];
          #1 chk("R6", {7'd0, irq_pending}, {7'd0, g[0] & |(r[3:0] & e[3:0])});
        end
      end
    end

    // R1: reset again from a nonzero state
    io_we = 1; io_wdata = 8'hff;
    tick("R2");
    idle(); rst_n = 0;
    tick("R1");
    rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule